// File: doc/BRIEF.md
# Banked register SPI slave

This block is a mode-0 SPI target that serves a byte-wide register file organised as four banks of 32 addresses. Addresses 0x1B to 0x1F form a window that is the same physical register whatever bank is selected. The active bank is held in bits 1:0 of the control register at 0x1F, which sits in that shared window, so software can always reach it. A frame starts when chip select falls and ends when it rises. The first byte carries a 3-bit opcode and a 5-bit address. The block supports register read, register write, bit-field set, bit-field clear and a one-byte system reset. The two buffer-memory command bytes are accepted, but there is no buffer behind them.

The SPI pins are resynchronised into the system clock domain, and all logic runs on that clock. SCK must therefore be several times slower than `clk`. A frame state machine steps through these states:
- `ST_IDLE`: chip select is inactive.
- `ST_CMD`: the command byte is being received.
- `ST_ARG`: the operand byte of a write, set or clear is being received.
- `ST_RDDUMMY`: the dummy byte of a MAC/MII read is being sent.
- `ST_RDDATA`: the read data byte is being sent.
- `ST_BUF`: a buffer command is streaming.
- `ST_RST`: a reset command is waiting for chip select to rise.
- `ST_DONE`: every further byte is ignored.

The transitions are named after what causes them:
- *select*: `ST_IDLE` to `ST_CMD` when chip select is seen low.
- *decode*: from `ST_CMD` at the end of the command byte, to `ST_BUF`, `ST_RDDUMMY`, `ST_RDDATA`, `ST_ARG`, `ST_RST` or `ST_DONE`.
- *commit*: `ST_ARG` to `ST_DONE`, which performs the write.
- *dummy-done*: `ST_RDDUMMY` to `ST_RDDATA`.
- *sent*: `ST_RDDATA` to `ST_DONE`.
- *overrun*: `ST_RST` to `ST_DONE` on any further SCK rise.
- *release*: any state back to `ST_IDLE` when chip select is seen high.

Top module: `bspi_banked_slave`

## Requirements
- R1: After `rst_n` every register reads 0x00, and `miso_oe` is low while `cs_n` is high.
- R2: A command byte is opcode in bits 7:5 and address in bits 4:0, sent MSB first. Opcode 010 writes the second byte to the address. Opcode 000 to an address that is not MAC/MII returns the value MSB first in the second byte. MISO is 0 during the command byte.
- R3: The bank is bits 1:0 of register 0x1F. Addresses 0x00 to 0x1A are separate per bank. Addresses 0x1B to 0x1F are shared by all banks.
- R4: Opcode 100 (bit-field set, 2 bytes) ORs the second byte into the addressed register.
- R5: Opcode 101 (bit-field clear, 2 bytes) ANDs the complement of the second byte into the addressed register.
- R6: Opcode 111 in a 1-byte frame clears bits 1:0 of 0x1F and leaves every other bit and register unchanged. A longer frame with that opcode has no effect.
- R7: The MAC/MII registers are the implemented addresses 0x00 to 0x1A of bank 2, plus bank 3 addresses 0x00 to 0x05 and 0x0A. A read of one of them is a 3-byte frame with a 0x00 dummy byte followed by the data.
- R8: The implemented addresses are:
  - 0x1B to 0x1F in every bank;
  - bank 0: 0x00 to 0x17;
  - bank 1: 0x00 to 0x11, 0x14, 0x15, 0x18 and 0x19;
  - bank 2: 0x00, 0x02 to 0x04, 0x06 to 0x0B, 0x12, 0x14 and 0x16 to 0x19;
  - bank 3: 0x00 to 0x0A, 0x12, 0x15 and 0x17 to 0x19.

  Every other address reads 0x00 in a 2-byte frame and ignores writes.
- R9: A write, set or clear takes effect only once the second byte is complete. A frame that chip select cuts short has no effect.
- R10: MISO changes only after a falling SCK edge while chip select is low. When chip select is high, `miso_oe` is low and `miso` is 0.
- R11: Command 0x3A returns 0x00 on every following byte, and command 0x7A discards its data. Opcodes 001 and 011 with other addresses, and opcode 110, change nothing.
- R12: Bytes after a completed command in the same frame change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must be several times faster than SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | High while the pad should drive MISO |

## Verification
The checker watches three things on every cycle:
- the MISO line moves only after a registered SCK fall, and is parked low when the block is deselected;
- the bank bits move only through an access to 0x1F or a reset command;
- set and clear on the control register leave the bank bits in a state consistent with the operand.

Some behaviour only the bench's frame scenarios can show. These are the data path through each bank, the shared window, the dummy byte on MAC/MII reads, the ignored addresses and commands, and frames cut short or overlong. In each case the value read back is compared with a behavioural model of the register file.

// File: rtl/bspi_pkg.sv
package bspi_pkg;
    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 5;
    localparam int NUM_BANKS   = 4;
    localparam int BANK_W      = $clog2(NUM_BANKS);
    localparam int BIT_W       = $clog2(DATA_W);
    localparam int COMMON_BASE = 27;
    localparam int NUM_COMMON  = (1 << ADDR_W) - COMMON_BASE;
    localparam int CIDX_W      = $clog2(NUM_COMMON);
    localparam int CTRL_IDX    = NUM_COMMON - 1;

    localparam logic [2:0] OPC_READ  = 3'b000;
    localparam logic [2:0] OPC_WRITE = 3'b010;
    localparam logic [2:0] OPC_SET   = 3'b100;
    localparam logic [2:0] OPC_CLR   = 3'b101;
    localparam logic [2:0] OPC_RESET = 3'b111;
    localparam logic [DATA_W-1:0] BUF_RD_CMD = 8'h3A;
    localparam logic [DATA_W-1:0] BUF_WR_CMD = 8'h7A;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CMD, ST_ARG, ST_RDDUMMY, ST_RDDATA, ST_BUF, ST_RST, ST_DONE
    } state_t;

    typedef enum logic [1:0] {WOP_WRITE, WOP_SET, WOP_CLR, WOP_RESET} wop_t;

    function automatic logic is_impl(logic [BANK_W-1:0] b, logic [ADDR_W-1:0] a);
        if (a >= ADDR_W'(COMMON_BASE)) return 1'b1;
        unique case (b)
            2'd0: return a <= 5'h17;
            2'd1: return (a <= 5'h11) || a == 5'h14 || a == 5'h15 || a == 5'h18 || a == 5'h19;
            2'd2: return a == 5'h00 || (a >= 5'h02 && a <= 5'h04) || (a >= 5'h06 && a <= 5'h0B)
                         || a == 5'h12 || a == 5'h14 || (a >= 5'h16 && a <= 5'h19);
            default: return (a <= 5'h0A) || a == 5'h12 || a == 5'h15 || (a >= 5'h17 && a <= 5'h19);
        endcase
    endfunction

    function automatic logic is_mac(logic [BANK_W-1:0] b, logic [ADDR_W-1:0] a);
        if (b == 2'd2) return (a < ADDR_W'(COMMON_BASE)) && is_impl(b, a);
        if (b == 2'd3) return (a <= 5'h05) || a == 5'h0A;
        return 1'b0;
    endfunction

    function automatic logic [CIDX_W-1:0] common_idx(logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] d;
        d = a - ADDR_W'(COMMON_BASE);
        return d[CIDX_W-1:0];
    endfunction
endpackage

// File: rtl/bspi_sync.sv
module bspi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic cs_n_in,
    input  logic mosi_in,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_act,
    output logic mosi_s
);
    logic [STAGES:0]   sck_p;
    logic [STAGES-1:0] cs_p;
    logic [STAGES-1:0] mo_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p <= '0;
            cs_p  <= '1;
            mo_p  <= '0;
        end else begin
            sck_p <= {sck_p[STAGES-1:0], sclk_in};
            cs_p  <= {cs_p[STAGES-2:0], cs_n_in};
            mo_p  <= {mo_p[STAGES-2:0], mosi_in};
        end
    end

    assign sck_rise = sck_p[STAGES-1] & ~sck_p[STAGES];
    assign sck_fall = ~sck_p[STAGES-1] & sck_p[STAGES];
    assign cs_act   = ~cs_p[STAGES-1];
    assign mosi_s   = mo_p[STAGES-1];
endmodule

// File: rtl/bspi_regfile.sv
module bspi_regfile
    import bspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  wop_t              wr_op,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [BANK_W-1:0] bank
);
    logic [DATA_W-1:0] banked_q [NUM_BANKS][COMMON_BASE];
    logic [DATA_W-1:0] common_q [NUM_COMMON];
    logic [DATA_W-1:0] cur_wr;
    logic [DATA_W-1:0] new_wr;

    assign bank = common_q[CTRL_IDX][BANK_W-1:0];

    always_comb begin
        rd_data = '0;
        if (is_impl(bank, rd_addr)) begin
            if (rd_addr >= ADDR_W'(COMMON_BASE)) rd_data = common_q[common_idx(rd_addr)];
            else                                 rd_data = banked_q[bank][rd_addr];
        end
    end

    always_comb begin
        if (wr_addr >= ADDR_W'(COMMON_BASE)) cur_wr = common_q[common_idx(wr_addr)];
        else                                 cur_wr = banked_q[bank][wr_addr];
        unique case (wr_op)
            WOP_WRITE: new_wr = wr_data;
            WOP_SET:   new_wr = cur_wr | wr_data;
            WOP_CLR:   new_wr = cur_wr & ~wr_data;
            default:   new_wr = cur_wr;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BANKS; b++)
                for (int a = 0; a < COMMON_BASE; a++)
                    banked_q[b][a] <= '0;
            for (int c = 0; c < NUM_COMMON; c++)
                common_q[c] <= '0;
        end else if (wr_en) begin
            if (wr_op == WOP_RESET)
                common_q[CTRL_IDX][BANK_W-1:0] <= '0;
            else if (is_impl(bank, wr_addr)) begin
                if (wr_addr >= ADDR_W'(COMMON_BASE)) common_q[common_idx(wr_addr)] <= new_wr;
                else                                 banked_q[bank][wr_addr] <= new_wr;
            end
        end
    end
endmodule

// File: rtl/bspi_frame_fsm.sv
module bspi_frame_fsm
    import bspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sck_rise,
    input  logic              mosi_s,
    input  logic [BANK_W-1:0] bank,
    output state_t            state,
    output logic [BIT_W-1:0]  bit_cnt,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              wr_en,
    output wop_t              wr_op,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    state_t            state_n;
    logic [DATA_W-1:0] rx_q;
    logic [DATA_W-1:0] cmd_q;
    logic [DATA_W-1:0] rx_next;
    logic              byte_done;
    logic [2:0]        opc;

    assign rx_next   = {rx_q[DATA_W-2:0], mosi_s};
    assign byte_done = sck_rise && (bit_cnt == BIT_W'(DATA_W - 1));
    assign opc       = rx_next[DATA_W-1:ADDR_W];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            rx_q    <= '0;
            cmd_q   <= '0;
        end else if (!cs_act) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
        end else begin
            state <= state_n;
            if (sck_rise) begin
                bit_cnt <= bit_cnt + 1'b1;
                rx_q    <= rx_next;
            end
            if (state == ST_CMD && byte_done) cmd_q <= rx_next;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (cs_act) state_n = ST_CMD;
            ST_CMD: if (byte_done) begin
                if (rx_next == BUF_RD_CMD || rx_next == BUF_WR_CMD) state_n = ST_BUF;
                else if (opc == OPC_READ)
                    state_n = is_mac(bank, rx_next[ADDR_W-1:0]) ? ST_RDDUMMY : ST_RDDATA;
                else if (opc == OPC_WRITE || opc == OPC_SET || opc == OPC_CLR) state_n = ST_ARG;
                else if (opc == OPC_RESET) state_n = ST_RST;
                else state_n = ST_DONE;
            end
            ST_ARG:     if (byte_done) state_n = ST_DONE;
            ST_RDDUMMY: if (byte_done) state_n = ST_RDDATA;
            ST_RDDATA:  if (byte_done) state_n = ST_DONE;
            ST_RST:     if (sck_rise)  state_n = ST_DONE;
            ST_BUF:     state_n = ST_BUF;
            ST_DONE:    state_n = ST_DONE;
        endcase
    end

    // outputs
    always_comb begin
        reg_addr = cmd_q[ADDR_W-1:0];
        wr_addr  = cmd_q[ADDR_W-1:0];
        wr_data  = rx_next;
        wr_en    = 1'b0;
        wr_op    = WOP_WRITE;
        if (state == ST_ARG && byte_done) begin
            wr_en = 1'b1;
            if (cmd_q[DATA_W-1:ADDR_W] == OPC_SET)      wr_op = WOP_SET;
            else if (cmd_q[DATA_W-1:ADDR_W] == OPC_CLR) wr_op = WOP_CLR;
        end else if (state == ST_RST && !cs_act) begin
            wr_en = 1'b1;
            wr_op = WOP_RESET;
        end
    end
endmodule

// File: rtl/bspi_banked_slave.sv
module bspi_banked_slave
    import bspi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic miso,
    output logic miso_oe
);
    logic              sck_rise, sck_fall, cs_act, mosi_s;
    state_t            state;
    logic [BIT_W-1:0]  bit_cnt;
    logic [ADDR_W-1:0] reg_addr, wr_addr;
    logic [DATA_W-1:0] rd_data, wr_data, tx_byte, tx_sh;
    logic              wr_en;
    wop_t              wr_op;
    logic [BANK_W-1:0] bank;

    bspi_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk), .cs_n_in(cs_n), .mosi_in(mosi),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act), .mosi_s(mosi_s)
    );

    bspi_frame_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_rise(sck_rise), .mosi_s(mosi_s),
        .bank(bank), .state(state), .bit_cnt(bit_cnt), .reg_addr(reg_addr),
        .wr_en(wr_en), .wr_op(wr_op), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    bspi_regfile regs_i (
        .clk(clk), .rst_n(rst_n), .rd_addr(reg_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_op(wr_op), .wr_addr(wr_addr), .wr_data(wr_data), .bank(bank)
    );

    assign tx_byte = (state == ST_RDDATA) ? rd_data : '0;
    assign miso_oe = cs_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            miso  <= 1'b0;
            tx_sh <= '0;
        end else if (!cs_act) begin
            miso  <= 1'b0;
            tx_sh <= '0;
        end else if (sck_fall) begin
            if (bit_cnt == '0) begin
                miso  <= tx_byte[DATA_W-1];
                tx_sh <= {tx_byte[DATA_W-2:0], 1'b0};
            end else begin
                miso  <= tx_sh[DATA_W-1];
                tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/bspi_checker.sv
module bspi_checker
    import bspi_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_act,
    input logic              sck_fall,
    input logic              miso,
    input logic              miso_oe,
    input logic              wr_en,
    input wop_t              wr_op,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [1:0]        wr_bits,
    input logic [1:0]        bank
);
    a_r10_miso_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && $past(cs_act) && !$stable(miso)) |-> $past(sck_fall));

    a_r10_miso_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (!miso_oe && $past(!miso_oe)) |-> !miso);

    a_r3_bank_by_ctrl_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bank) |-> ($past(wr_en) && ($past(wr_addr) == 5'h1F || $past(wr_op) == WOP_RESET)));

    a_r6_reset_clears_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == WOP_RESET) |=> (bank == 2'b00));

    a_r4_set_raises_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == WOP_SET && wr_addr == 5'h1F) |=> ((bank & $past(wr_bits)) == $past(wr_bits)));

    a_r5_clear_drops_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == WOP_CLR && wr_addr == 5'h1F) |=> ((bank & $past(wr_bits)) == 2'b00));
endmodule

bind bspi_banked_slave bspi_checker chk_i (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_fall(sck_fall), .miso(miso),
    .miso_oe(miso_oe), .wr_en(wr_en), .wr_op(wr_op), .wr_addr(wr_addr),
    .wr_bits(wr_data[1:0]), .bank(bank)
);

// File: tb/bspi_banked_slave_tb_top.sv
module bspi_banked_slave_tb_top;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso, miso_oe;

    int checks = 0;
    int errors = 0;
    logic [7:0] mem [4][32];
    logic [7:0] txb [4];
    logic [7:0] rxb [4];

    always #5 clk = ~clk;

    bspi_banked_slave dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe)
    );

    function automatic bit impl_ref(int b, int a);
        if (a >= 27) return 1;
        if (b == 0) return !(a inside {24, 25, 26});
        if (b == 1) return !(a inside {18, 19, 22, 23, 26});
        if (b == 2) return !(a inside {1, 5, [12:17], 19, 21, 26});
        return !(a inside {[11:17], 19, 20, 22, 26});
    endfunction

    function automatic bit mac_ref(int b, int a);
        if (b == 2) return a < 27 && impl_ref(b, a);
        if (b == 3) return a <= 5 || a == 10;
        return 0;
    endfunction

    function automatic int cur_bank();
        return int'(mem[0][31][1:0]);
    endfunction

    function automatic int slot(int b, int a);
        return (a >= 27) ? 0 : b;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, output logic r);
        mosi = b;
        repeat (HALF) @(negedge clk);
        r = miso;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    // n whole bytes, then cut extra bits of txb[n] before raising chip select
    task automatic xfer(input int n, input int cut);
        logic r;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            for (int i = 7; i >= 0; i--) begin
                send_bit(txb[k][i], r);
                rxb[k][i] = r;
            end
        end
        for (int i = 7; i > 7 - cut; i--) send_bit(txb[n][i], r);
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        txb[0] = 8'h40 | 8'(a); txb[1] = d;
        xfer(2, 0);
        if (impl_ref(cur_bank(), a)) mem[slot(cur_bank(), a)][a] = d;
    endtask

    task automatic bfs(input int a, input logic [7:0] d);
        txb[0] = 8'h80 | 8'(a); txb[1] = d;
        xfer(2, 0);
        if (impl_ref(cur_bank(), a)) mem[slot(cur_bank(), a)][a] |= d;
    endtask

    task automatic bfc(input int a, input logic [7:0] d);
        txb[0] = 8'hA0 | 8'(a); txb[1] = d;
        xfer(2, 0);
        if (impl_ref(cur_bank(), a)) mem[slot(cur_bank(), a)][a] &= ~d;
    endtask

    task automatic rd(input int a, input string tag);
        int b;
        logic [7:0] exp;
        b = cur_bank();
        exp = impl_ref(b, a) ? mem[slot(b, a)][a] : 8'h00;
        txb[0] = 8'(a); txb[1] = 8'h00; txb[2] = 8'h00;
        if (mac_ref(b, a)) begin
            xfer(3, 0);
            check({tag, " R7 dummy byte"}, rxb[1], 8'h00);
            check({tag, " R7 data after dummy"}, rxb[2], exp);
        end else begin
            xfer(2, 0);
            check({tag, " read data"}, rxb[1], exp);
        end
        check({tag, " R2 miso during command"}, rxb[0], 8'h00);
    endtask

    // per-clock comparison of pin behaviour against the expected line state (R10)
    int hi_cnt = 0;
    int lo_cnt = 0;
    logic prev_miso = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_n) begin hi_cnt++; lo_cnt = 0; end
            else begin lo_cnt++; hi_cnt = 0; end
            if (hi_cnt > 4) begin
                checks++;
                if (miso_oe !== 1'b0 || miso !== 1'b0) begin
                    errors++;
                    $display("FAIL R10 deselected actual oe=%b miso=%b expected oe=0 miso=0", miso_oe, miso);
                end
            end
            if (lo_cnt > 4) begin
                checks++;
                if (miso_oe !== 1'b1) begin
                    errors++;
                    $display("FAIL R10 selected actual oe=%b expected oe=1", miso_oe);
                end
            end
            if (!cs_n && lo_cnt > 4 && miso !== prev_miso) begin
                checks++;
                if (sclk !== 1'b0) begin
                    errors++;
                    $display("FAIL R10 miso moved with sck actual sck=%b expected sck=0", sclk);
                end
            end
            prev_miso = miso;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int b = 0; b < 4; b++)
            for (int a = 0; a < 32; a++) mem[b][a] = 8'h00;
        repeat (5) @(negedge clk);
        check("R1 oe low after reset", {7'd0, miso_oe}, 8'h00);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        rd(31, "R1 ctrl reset");
        rd(5, "R1 bank0 reset");

        wr(5, 8'hA5);  rd(5, "R2 bank0 0x05");
        wr(23, 8'h3C); rd(23, "R2 bank0 0x17");
        wr(0, 8'hFF);  rd(0, "R2 bank0 0x00");

        wr(31, 8'h01); wr(5, 8'h5A); rd(5, "R3 bank1 0x05");
        wr(28, 8'hA0);
        wr(31, 8'h02); rd(28, "R3 shared 0x1C from bank2");
        wr(31, 8'h00); rd(5, "R3 bank0 kept 0x05");

        bfs(28, 8'h0F); rd(28, "R4 set 0x1C");
        bfs(31, 8'h03); rd(31, "R4 set bank bits");
        wr(10, 8'h66);  rd(10, "R7 bank3 0x0A");
        wr(7, 8'h44);   rd(7, "R7 bank3 0x07 plain");
        bfc(31, 8'h02); rd(31, "R5 clear bank bit");
        bfc(28, 8'h21); rd(28, "R5 clear 0x1C");

        wr(18, 8'hFF); rd(18, "R8 bank1 0x12 unimpl");
        wr(26, 8'h55); rd(26, "R8 bank1 0x1A unimpl");
        wr(31, 8'h02);
        wr(0, 8'h77);  rd(0, "R7 bank2 0x00");
        wr(1, 8'h99);  rd(1, "R8 bank2 0x01 unimpl");
        wr(25, 8'h12); rd(25, "R7 bank2 0x19");

        wr(31, 8'hF3);
        txb[0] = 8'hFF; xfer(1, 0); mem[0][31] &= 8'hFC;
        rd(31, "R6 reset clears bank");
        rd(5, "R6 bank0 after reset");
        wr(31, 8'h01);
        txb[0] = 8'hFF; txb[1] = 8'h00; xfer(2, 0);
        rd(31, "R6 long reset ignored");
        wr(31, 8'h00);

        txb[0] = 8'h45; txb[1] = 8'h3C; xfer(1, 5);
        rd(5, "R9 cut write");
        txb[0] = 8'h45; xfer(1, 0);
        rd(5, "R9 command only");
        txb[0] = 8'h9C; txb[1] = 8'hFF; xfer(1, 7);
        rd(28, "R9 cut set");

        txb[0] = 8'h3A; txb[1] = 8'h12; txb[2] = 8'h34; txb[3] = 8'h56; xfer(4, 0);
        check("R11 buffer read byte1", rxb[1], 8'h00);
        check("R11 buffer read byte3", rxb[3], 8'h00);
        txb[0] = 8'h7A; txb[1] = 8'h11; txb[2] = 8'h22; xfer(3, 0);
        rd(5, "R11 buffer write discarded");
        rd(31, "R11 ctrl after buffer write");
        txb[0] = 8'hC5; txb[1] = 8'hFF; xfer(2, 0);
        rd(5, "R11 opcode 110 ignored");
        txb[0] = 8'h25; txb[1] = 8'hFF; xfer(2, 0);
        rd(5, "R11 opcode 001 ignored");

        txb[0] = 8'h45; txb[1] = 8'h11; txb[2] = 8'h22; xfer(3, 0);
        mem[0][5] = 8'h11;
        rd(5, "R12 extra byte ignored");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule